// File: doc/BRIEF.md
# Parallel Port Nibble-Mode Reverse Receiver

This block is the host side of the reverse channel of an IEEE 1284 port running in nibble mode. The link is assumed to be in nibble mode already. On a start pulse it reads a requested number of bytes from the peripheral. Each byte arrives as two 4-bit halves on the peripheral status lines. For each half the block runs a two-phase handshake: it pulls its feed-request line low, waits for the acknowledge line to fall, and captures the four status pins. It then releases the request line and waits for the acknowledge line to rise again.

Completed bytes leave the block on a valid/ready stream. The block issues no further request to the peripheral until the consumer has taken the byte on offer. Every wait is bounded by a tick counter, and a tick comes from a prescaler on the clock. If any wait runs out, the transfer ends with an error flag set, and the number of bytes that did complete is reported. The select-in and strobe lines stay high for the whole transfer.

Top module: `nibble_rx`

## Requirements
- R1: After reset, host_feed_n, host_selin_n and host_strobe_n are high, and out_valid, done_o, err_o and busy_o are low.
- R2: host_selin_n and host_strobe_n stay high at all times, including during transfers.
- R3: A start with a nonzero req_count drives host_feed_n low. host_feed_n stays low until periph_ack_n is seen low, unless the wait times out.
- R4: When periph_ack_n is seen low, the captured nibble has stat_fault in bit 0, stat_sel in bit 1, stat_perr in bit 2 and stat_busy in bit 3. Each pin is taken at its raw level.
- R5: The first nibble of a byte becomes out_data[3:0] and the second becomes out_data[7:4].
- R6: The wait for the first nibble of a byte may last IDLE_TICKS ticks. Every other wait, meaning the second nibble and each acknowledge release, may last RESP_TICKS ticks. When a wait expires, done_o pulses with err_o high, and bytes_o holds the number of bytes already accepted.
- R7: out_valid stays high and out_data stays stable until out_ready is seen. host_feed_n stays high while out_valid is high.
- R8: After req_count bytes have been accepted, done_o pulses for one cycle with err_o low and bytes_o equal to req_count.
- R9: A start with req_count of 0 gives done_o in the next cycle, with err_o low, bytes_o 0, and no change on host_feed_n.
- R10: One tick is TICK_DIV clock cycles. The timeout counter reloads at the start of every wait, so a long sequence of waits that each come close to the limit still succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that starts a read of req_count bytes |
| req_count | input | CNT_W | Number of bytes to read |
| periph_ack_n | input | 1 | Peripheral acknowledge, active low |
| stat_fault | input | 1 | Status pin for nibble bit 0 |
| stat_sel | input | 1 | Status pin for nibble bit 1 |
| stat_perr | input | 1 | Status pin for nibble bit 2 |
| stat_busy | input | 1 | Status pin for nibble bit 3 |
| host_feed_n | output | 1 | Nibble request to the peripheral, active low |
| host_selin_n | output | 1 | Select-in line, held high |
| host_strobe_n | output | 1 | Strobe line, held high |
| out_data | output | 8 | Assembled byte |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | Consumer takes the byte |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| err_o | output | 1 | The last transfer ended on a timeout |
| bytes_o | output | CNT_W | Bytes completed in the current or last transfer |

## Verification
The bench builds the block with TICK_DIV=2, IDLE_TICKS=40 and RESP_TICKS=6. With these values, a first-nibble timeout lasts 80 cycles and every other timeout lasts 12 cycles. That makes it practical to measure each timeout to within a cycle or two, to answer just inside each limit, and to fail each wait kind in turn. A tick divider above one also checks that the prescaler restarts together with the wait counter.

// File: rtl/nibble_rx.sv
module nibble_rx #(
  parameter int TICK_DIV   = 4,
  parameter int IDLE_TICKS = 2000,
  parameter int RESP_TICKS = 6,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] req_count,
  input  logic             periph_ack_n,
  input  logic             stat_fault,
  input  logic             stat_sel,
  input  logic             stat_perr,
  input  logic             stat_busy,
  output logic             host_feed_n,
  output logic             host_selin_n,
  output logic             host_strobe_n,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] bytes_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int LW = (IDLE_TICKS > RESP_TICKS) ? IDLE_TICKS : RESP_TICKS;
  localparam int WW = $clog2(LW + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [WW-1:0] W_IDLE = WW'(IDLE_TICKS);
  localparam logic [WW-1:0] W_RESP = WW'(RESP_TICKS);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_REL, S_OUT} st_t;

  st_t             st;
  logic            phase;
  logic [3:0]      lo;
  logic [PW-1:0]   pre;
  logic [WW-1:0]   wcnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] next_bytes;

  wire [3:0] nib    = {stat_busy, stat_perr, stat_sel, stat_fault};
  wire       tick   = (pre == PRE_LAST);
  wire       expire = tick && (wcnt == WW'(1));

  assign next_bytes    = bytes_o + CNT_W'(1);
  assign host_feed_n   = (st != S_REQ);
  assign host_selin_n  = 1'b1;
  assign host_strobe_n = 1'b1;
  assign out_valid     = (st == S_OUT);
  assign busy_o        = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      phase    <= 1'b0;
      lo       <= '0;
      out_data <= '0;
      pre      <= '0;
      wcnt     <= '0;
      target   <= '0;
      bytes_o  <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          bytes_o <= '0;
          err_o   <= 1'b0;
          target  <= req_count;
          if (req_count == '0) done_o <= 1'b1;
          else begin
            st    <= S_REQ;
            phase <= 1'b0;
            pre   <= '0;
            wcnt  <= W_IDLE;
          end
        end
        S_REQ: begin
          if (!periph_ack_n) begin
            if (!phase) lo <= nib;
            else        out_data <= {nib, lo};
            st   <= S_REL;
            pre  <= '0;
            wcnt <= W_RESP;
          end else if (expire) begin
            st     <= S_IDLE;
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end else begin
            pre <= tick ? '0 : pre + PW'(1);
            if (tick) wcnt <= wcnt - WW'(1);
          end
        end
        S_REL: begin
          if (periph_ack_n) begin
            if (!phase) begin
              phase <= 1'b1;
              st    <= S_REQ;
              pre   <= '0;
              wcnt  <= W_RESP;
            end else st <= S_OUT;
          end else if (expire) begin
            st     <= S_IDLE;
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end else begin
            pre <= tick ? '0 : pre + PW'(1);
            if (tick) wcnt <= wcnt - WW'(1);
          end
        end
        default: if (out_ready) begin
          bytes_o <= next_bytes;
          if (next_bytes == target) begin
            st     <= S_IDLE;
            done_o <= 1'b1;
          end else begin
            st    <= S_REQ;
            phase <= 1'b0;
            pre   <= '0;
            wcnt  <= W_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nibble_rx_chk.sv
module nibble_rx_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_feed_n,
  input logic             host_selin_n,
  input logic             host_strobe_n,
  input logic             periph_ack_n,
  input logic [7:0]       out_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic             done_o,
  input logic             err_o,
  input logic [CNT_W-1:0] bytes_o
);
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7

  AST_NO_REQ_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> host_feed_n); // R7

  AST_FEED_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_feed_n) |-> (!$past(periph_ack_n) || err_o)); // R3

  AST_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_selin_n && host_strobe_n); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bytes_o != $past(bytes_o)) |-> (bytes_o == $past(bytes_o) + CNT_W'(1) || bytes_o == '0)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
endmodule

bind nibble_rx nibble_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_feed_n(host_feed_n),
  .host_selin_n(host_selin_n), .host_strobe_n(host_strobe_n),
  .periph_ack_n(periph_ack_n), .out_data(out_data), .out_valid(out_valid),
  .out_ready(out_ready), .done_o(done_o), .err_o(err_o), .bytes_o(bytes_o));

// File: tb/test_nibble_rx.sv
module test_nibble_rx;
  localparam int DIV = 2, IDLE = 40, RESP = 6, CW = 8;

  logic clk = 0, rst_n = 0, start = 0, out_ready = 0;
  logic [CW-1:0] req_count = '0;
  logic ack_n = 1, s_fault = 0, s_sel = 0, s_perr = 0, s_busy = 0;
  logic feed_n, selin_n, strobe_n, out_valid, busy, done, err;
  logic [7:0] out_data;
  logic [CW-1:0] bytes;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nibble_rx #(.TICK_DIV(DIV), .IDLE_TICKS(IDLE), .RESP_TICKS(RESP), .CNT_W(CW)) i_nibble_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .req_count(req_count),
    .periph_ack_n(ack_n), .stat_fault(s_fault), .stat_sel(s_sel),
    .stat_perr(s_perr), .stat_busy(s_busy), .host_feed_n(feed_n),
    .host_selin_n(selin_n), .host_strobe_n(strobe_n), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .busy_o(busy),
    .done_o(done), .err_o(err), .bytes_o(bytes));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start(input int n);
    @(negedge clk); start = 1; req_count = CW'(n);
    @(negedge clk); start = 0;
  endtask

  // one nibble from the peripheral side; d_rel < 0 means never release ack
  task automatic periph(input logic [3:0] nib, input int d_req, input int d_rel);
    int g = 0;
    while (feed_n && g < 2000) begin @(negedge clk); g++; end
    chk(!feed_n, "R3 feed request", feed_n, 0);
    for (int i = 0; i < d_req; i++) begin
      @(negedge clk);
      if (feed_n || !selin_n || !strobe_n) chk(0, "R3/R2 request held", {feed_n, selin_n, strobe_n}, 3);
    end
    {s_busy, s_perr, s_sel, s_fault} = nib;
    ack_n = 0;
    if (d_rel < 0) return;
    g = 0;
    while (!feed_n && g < 2000) begin @(negedge clk); g++; end
    chk(feed_n, "R3 feed release", feed_n, 1);
    for (int i = 0; i < d_rel; i++) @(negedge clk);
    ack_n = 1;
  endtask

  task automatic recv(input logic [7:0] exp, input int hold);
    int g = 0;
    while (!out_valid && g < 2000) begin @(negedge clk); g++; end
    chk(out_valid && out_data == exp, "R4 R5 byte value", out_data, exp);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!out_valid || out_data != exp || !feed_n) chk(0, "R7 hold", out_data, exp);
    end
    out_ready = 1;
    @(negedge clk); out_ready = 0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_reset;
    chk(feed_n && selin_n && strobe_n && !out_valid && !done && !err && !busy,
        "R1 reset state", {feed_n, selin_n, strobe_n, out_valid, done, err, busy}, 7'b1110000);
  endtask

  task automatic t_zero;
    do_start(0);
    chk(done && !err && bytes == 0 && feed_n, "R9 zero count", {done, err, feed_n}, 3'b101);
    @(negedge clk);
  endtask

  task automatic t_bytes;
    logic [7:0] pat [4] = '{8'hA5, 8'h3C, 8'hF0, 8'h01};
    do_start(4);
    chk(busy, "R3 busy", busy, 1);
    for (int b = 0; b < 4; b++) begin
      periph(pat[b][3:0], 2 + b, 1 + b);
      periph(pat[b][7:4], 3, 2);
      recv(pat[b], b * 3);
    end
    chk(done && !err && bytes == 4, "R8 completion", bytes, 4);
    @(negedge clk);
    chk(!done, "R8 done pulse", done, 0);
  endtask

  task automatic t_bits;
    logic [3:0] one;
    for (int k = 0; k < 4; k++) begin
      one = 4'b1 << k;
      do_start(1);
      periph(one, 1, 1);
      periph(~one, 1, 1);
      recv({~one, one}, 0);
      chk(done && !err, "R4 single pin map", k, k);
    end
  endtask

  task automatic t_first_timeout;
    int c;
    do_start(1);
    wait_done(c);
    chk(c >= IDLE*DIV - 1 && c <= IDLE*DIV + 2, "R6 idle limit length", c, IDLE*DIV);
    chk(err && bytes == 0 && feed_n, "R6 idle timeout error", {err, bytes}, 256);
    @(negedge clk);
  endtask

  task automatic t_late_ok;
    do_start(3);
    for (int b = 0; b < 3; b++) begin
      periph(4'h6, IDLE*DIV - 5, RESP*DIV - 4);
      periph(4'h9, RESP*DIV - 4, RESP*DIV - 4);
      recv(8'h96, 1);
    end
    chk(done && !err && bytes == 3, "R10 reload near limit", bytes, 3);
    @(negedge clk);
  endtask

  task automatic t_second_timeout;
    int c;
    do_start(2);
    periph(4'h1, 1, 1); periph(4'h2, 1, 1); recv(8'h21, 0);
    periph(4'h7, 1, 1);
    wait_done(c);
    chk(c >= RESP*DIV - 1 && c <= RESP*DIV + 3, "R6 second nibble limit", c, RESP*DIV);
    chk(err && bytes == 1, "R6 partial count", bytes, 1);
    @(negedge clk);
  endtask

  task automatic t_release_timeout;
    int c;
    do_start(1);
    periph(4'h5, 1, -1);
    wait_done(c);
    chk(c >= RESP*DIV - 1 && c <= RESP*DIV + 3, "R6 release limit", c, RESP*DIV);
    chk(err && bytes == 0, "R6 release error", err, 1);
    ack_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_bytes();
    t_bits();
    t_first_timeout();
    t_late_ok();
    t_second_timeout();
    t_release_timeout();
    t_zero();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule